// File: doc/BRIEF.md
# Multi-Mode Serial Readout Port Multiplexer

This block takes one 128-channel event, offered by an upstream derandomizing buffer over a valid/ready handshake, and sends it out serially on one, two or four single-bit ports. In the four-port grouping each port carries a quarter of the channels. In the two-port grouping each of two ports carries half of them. In the single-port grouping one port carries every channel. Each active port sends one channel per clock, lowest channel first. A common data-valid strobe frames the transfer.

A fourth mode runs the single-port grouping as one link of a daisy chain. Several chips then share one readout line, and their outputs are combined by an external OR. A chip in this mode drives its port only while it holds a token. Outside that window it drives zeros. When its last bit has gone out it hands the token on with a one-cycle pulse. A chip that holds no event passes an arriving token straight on.

Back-pressure: `ev_ready` is high only while no event is latched. An event transfers on a clock edge where `ev_valid` and `ev_ready` are both high. While `ev_valid` is high and `ev_ready` is low, the source must hold `ev_data` and `mode` stable. The mode is taken into account only at the moment an event is accepted.

Top module: `rdout_port_mux`

## Requirements
- R1: While `rst_n` is low, `ser_valid`, `ser_data` and `tok_out` are 0 and `ev_ready` is 1.
- R2: `ev_ready` is 1 exactly when no event is latched. It drops in the cycle after an accepting edge and returns in the cycle after the last bit of the frame. An event offered while `ev_ready` is low waits, with no data lost.
- R3: With `mode`=0 (four ports), on the i-th valid cycle (i = 0..31) port k (`ser_data[k]`, k = 0..3) carries channel 32k+i of the accepted event.
- R4: With `mode`=1 (two ports), on the i-th valid cycle (i = 0..63) `ser_data[k]` for k = 0..1 carries channel 64k+i, and `ser_data[3:2]` is 0.
- R5: With `mode`=2 (one port), on the i-th valid cycle (i = 0..127) `ser_data[0]` carries channel i, and `ser_data[3:1]` is 0.
- R6: In modes 0 to 2, `ser_valid` rises in the cycle after the accepting edge. It stays high for exactly 32, 64 or 128 cycles and then falls.
- R7: `ser_data` is all zero in every cycle where `ser_valid` is low.
- R8: The mode in force during a frame is the value `mode` had at the accepting edge. A change of `mode` during a frame has no effect on that frame.
- R9: With `mode`=3 (chained single port, same channel order as R5), after acceptance `ser_valid` stays low until an edge where `tok_in` is 1. It rises in the cycle after that edge. If `tok_in` is 1 at the accepting edge, it rises in the cycle after acceptance.
- R10: In mode 3, `tok_out` is high for exactly one cycle, the cycle after the last bit of the frame.
- R11: With `mode`=3 and no event latched or accepted, a `tok_in` of 1 at an edge gives `tok_out`=1 for the following cycle only.
- R12: In modes 0 to 2, `tok_in` is ignored and `tok_out` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Readout clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| ev_valid | input | 1 | Event offered by the upstream buffer |
| ev_ready | output | 1 | Block can take an event |
| ev_data | input | 128 | Channel bits of the event, bit n is channel n |
| mode | input | 2 | 0 four ports, 1 two ports, 2 one port, 3 one port chained |
| tok_in | input | 1 | Token from the previous chip of the chain |
| ser_valid | output | 1 | Frame strobe, high while channel bits are on the ports |
| ser_data | output | 4 | Serial output bit per port |
| tok_out | output | 1 | Token pulse to the next chip of the chain |

## Verification
The assertions assume that `tok_in` arrives as pulses of a single cycle. They also assume that `mode` and `ev_data` stay stable while an offered event is waiting for `ev_ready`. The bench's tasks change `mode` only at acceptance, or on purpose in the middle of a frame that has already latched its mode. They hold `ev_valid` with unchanged data until the handshake completes. Every token is driven high at one falling edge and low at the next, so that exactly one rising edge samples it.

// File: rtl/rdm_pkg.sv
package rdm_pkg;

  localparam int MAX_PORTS = 4;

  typedef enum logic [1:0] {
    MODE_QUAD   = 2'd0,
    MODE_DUAL   = 2'd1,
    MODE_SINGLE = 2'd2,
    MODE_CHAIN  = 2'd3
  } rd_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_WAIT_TOK = 2'd1,
    ST_SEND     = 2'd2
  } rd_state_e;

endpackage

// File: rtl/rdm_ctrl.sv
module rdm_ctrl
  import rdm_pkg::*;
#(
  parameter int NUM_CH = 128
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     ev_valid,
  input  rd_mode_e mode_in,
  input  logic     tok_in,
  output logic     ev_ready,
  output logic     load,
  output logic     shift_en,
  output rd_mode_e mode_q,
  output logic     tok_out
);

  localparam int CNT_W = $clog2(NUM_CH);
  localparam logic [CNT_W-1:0] LAST_QUAD = CNT_W'(NUM_CH / 4 - 1);
  localparam logic [CNT_W-1:0] LAST_DUAL = CNT_W'(NUM_CH / 2 - 1);
  localparam logic [CNT_W-1:0] LAST_ONE  = CNT_W'(NUM_CH - 1);

  rd_state_e        state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last_idx;

  always_comb begin
    case (mode_q)
      MODE_QUAD: last_idx = LAST_QUAD;
      MODE_DUAL: last_idx = LAST_DUAL;
      default:   last_idx = LAST_ONE;
    endcase
  end

  assign ev_ready = (state_q == ST_IDLE);
  assign load     = ev_valid && ev_ready;
  assign shift_en = (state_q == ST_SEND);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      mode_q  <= MODE_QUAD;
      tok_out <= 1'b0;
    end else begin
      tok_out <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (ev_valid) begin
            mode_q  <= mode_in;
            cnt_q   <= '0;
            state_q <= (mode_in == MODE_CHAIN && !tok_in) ? ST_WAIT_TOK : ST_SEND;
          end else if (mode_in == MODE_CHAIN && tok_in) begin
            // no event held: hand the token straight on
            tok_out <= 1'b1;
          end
        end
        ST_WAIT_TOK: begin
          if (tok_in) state_q <= ST_SEND;
        end
        ST_SEND: begin
          if (cnt_q == last_idx) begin
            state_q <= ST_IDLE;
            tok_out <= (mode_q == MODE_CHAIN);
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/rdm_lanes.sv
module rdm_lanes
  import rdm_pkg::*;
#(
  parameter int NUM_CH = 128
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load,
  input  logic                 shift_en,
  input  logic [NUM_CH-1:0]    ev_data,
  input  rd_mode_e             mode_q,
  output logic [MAX_PORTS-1:0] ser_data
);

  localparam int QUAD_SEG = NUM_CH / 4;
  localparam int DUAL_SEG = NUM_CH / 2;

  // One shared register shifted right once per bit: the head of every
  // segment then always holds the next channel of that segment.
  logic [NUM_CH-1:0] frame_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      frame_q <= '0;
    end else if (load) begin
      frame_q <= ev_data;
    end else if (shift_en) begin
      frame_q <= frame_q >> 1;
    end
  end

  for (genvar k = 0; k < MAX_PORTS; k++) begin : g_port
    localparam bit HAS_DUAL = (k < 2);
    localparam bit HAS_ONE  = (k == 0);
    localparam int DUAL_IDX = HAS_DUAL ? k * DUAL_SEG : 0;
    logic bit_sel;

    always_comb begin
      case (mode_q)
        MODE_QUAD: bit_sel = frame_q[k*QUAD_SEG];
        MODE_DUAL: bit_sel = frame_q[DUAL_IDX] & HAS_DUAL;
        default:   bit_sel = frame_q[0] & HAS_ONE;
      endcase
    end

    assign ser_data[k] = bit_sel & shift_en;
  end

endmodule

// File: rtl/rdout_port_mux.sv
module rdout_port_mux
  import rdm_pkg::*;
#(
  parameter int NUM_CH = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_valid,
  output logic              ev_ready,
  input  logic [NUM_CH-1:0] ev_data,
  input  logic [1:0]        mode,
  input  logic              tok_in,
  output logic              ser_valid,
  output logic [3:0]        ser_data,
  output logic              tok_out
);

  logic     load;
  logic     shift_en;
  rd_mode_e mode_q;

  rdm_ctrl #(.NUM_CH(NUM_CH)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .ev_valid (ev_valid),
    .mode_in  (rd_mode_e'(mode)),
    .tok_in   (tok_in),
    .ev_ready (ev_ready),
    .load     (load),
    .shift_en (shift_en),
    .mode_q   (mode_q),
    .tok_out  (tok_out)
  );

  rdm_lanes #(.NUM_CH(NUM_CH)) u_lanes (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .shift_en (shift_en),
    .ev_data  (ev_data),
    .mode_q   (mode_q),
    .ser_data (ser_data)
  );

  assign ser_valid = shift_en;

endmodule

// File: rtl/rdm_checker.sv
module rdm_checker #(
  parameter int NUM_CH = 128
) (
  input logic       clk,
  input logic       rst_n,
  input logic       ev_valid,
  input logic       ev_ready,
  input logic [1:0] mode,
  input logic       tok_in,
  input logic       ser_valid,
  input logic [3:0] ser_data,
  input logic       tok_out
);

  logic [1:0] acc_mode;
  logic       chain_q;
  int         run_len;
  int         exp_len;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_mode <= 2'd0;
      chain_q  <= 1'b0;
      run_len  <= 0;
    end else begin
      if (ev_valid && ev_ready) begin
        acc_mode <= mode;
        chain_q  <= (mode == 2'd3);
      end
      run_len <= ser_valid ? run_len + 1 : 0;
    end
  end

  always_comb begin
    case (acc_mode)
      2'd0:    exp_len = NUM_CH / 4;
      2'd1:    exp_len = NUM_CH / 2;
      default: exp_len = NUM_CH;
    endcase
  end

  assert_handshake_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && ev_ready) |=> !ev_ready);

  assert_frame_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ser_valid) |-> (run_len == exp_len && ev_ready));

  assert_quiet_lines_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !ser_valid |-> (ser_data == 4'd0));

  assert_token_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ser_valid) && chain_q) |-> $past(tok_in));

  assert_token_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    tok_out |=> !tok_out);

  assert_no_token_R12: assert property (@(posedge clk) disable iff (!rst_n)
    tok_out |-> ($past(mode) == 2'd3 || chain_q));

endmodule

bind rdout_port_mux rdm_checker #(.NUM_CH(NUM_CH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ev_valid  (ev_valid),
  .ev_ready  (ev_ready),
  .mode      (mode),
  .tok_in    (tok_in),
  .ser_valid (ser_valid),
  .ser_data  (ser_data),
  .tok_out   (tok_out)
);

// File: tb/rdout_port_mux_bench.sv
module rdout_port_mux_bench;

  localparam int NCH = 128;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           ev_valid;
  logic           ev_ready;
  logic [NCH-1:0] ev_data;
  logic [1:0]     mode;
  logic           tok_in;
  logic           ser_valid;
  logic [3:0]     ser_data;
  logic           tok_out;

  int    checks = 0;
  int    errors = 0;
  int    tok_seen = 0;
  string cur_req = "R1";

  always #5 clk = ~clk;

  rdout_port_mux #(.NUM_CH(NCH)) u_rdout_port_mux (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_ready(ev_ready),
    .ev_data(ev_data), .mode(mode), .tok_in(tok_in), .ser_valid(ser_valid),
    .ser_data(ser_data), .tok_out(tok_out)
  );

  // ---------------- behavioural reference ----------------
  int             m_phase;   // 0 empty, 1 holding event without token, 2 sending
  int             m_idx;
  int             m_mode;
  logic [NCH-1:0] m_data;
  logic           m_tok;

  function automatic int frame_len(int md);
    if (md == 0) return NCH / 4;
    if (md == 1) return NCH / 2;
    return NCH;
  endfunction

  function automatic logic [3:0] exp_bits();
    logic [3:0] b = 4'd0;
    if (m_phase == 2) begin
      if (m_mode == 0) begin
        for (int k = 0; k < 4; k++) b[k] = m_data[k * (NCH / 4) + m_idx];
      end else if (m_mode == 1) begin
        for (int k = 0; k < 2; k++) b[k] = m_data[k * (NCH / 2) + m_idx];
      end else begin
        b[0] = m_data[m_idx];
      end
    end
    return b;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_phase = 0; m_idx = 0; m_mode = 0; m_data = '0; m_tok = 1'b0;
    end else begin
      m_tok = 1'b0;
      if (m_phase == 0) begin
        if (ev_valid) begin
          m_data  = ev_data;
          m_mode  = int'(mode);
          m_idx   = 0;
          m_phase = (mode == 2'd3 && !tok_in) ? 1 : 2;
        end else if (mode == 2'd3 && tok_in) begin
          m_tok = 1'b1;
        end
      end else if (m_phase == 1) begin
        if (tok_in) m_phase = 2;
      end else begin
        if (m_idx == frame_len(m_mode) - 1) begin
          m_phase = 0;
          m_tok   = (m_mode == 3);
        end else begin
          m_idx = m_idx + 1;
        end
      end
    end
  end

  task automatic check(input string what, input logic [3:0] got, input logic [3:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s got %h exp %h at %0t", cur_req, what, got, exp, $time);
    end
  endtask

  // every cycle: compare ports against the reference
  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      check("ev_ready",  {3'd0, ev_ready},  {3'd0, m_phase == 0});
      check("ser_valid", {3'd0, ser_valid}, {3'd0, m_phase == 2});
      check("ser_data",  ser_data,          exp_bits());
      check("tok_out",   {3'd0, tok_out},   {3'd0, m_tok});
      if (tok_out) tok_seen++;
    end
  end

  // ---------------- stimulus ----------------
  task automatic send(input logic [NCH-1:0] d, input logic [1:0] md);
    ev_data  = d;
    mode     = md;
    ev_valid = 1'b1;
    while (!ev_ready) @(negedge clk);
    @(negedge clk);
    ev_valid = 1'b0;
  endtask

  task automatic wait_idle();
    while (!ev_ready) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic pulse_tok();
    tok_in = 1'b1;
    @(negedge clk);
    tok_in = 1'b0;
  endtask

  function automatic logic [NCH-1:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  int tok_before;

  initial begin
    rst_n = 1'b0; ev_valid = 1'b0; ev_data = '0; mode = 2'd0; tok_in = 1'b0;
    repeat (3) @(negedge clk);
    cur_req = "R1";
    check("reset ser_valid", {3'd0, ser_valid}, 4'd0);
    check("reset ser_data",  ser_data,          4'd0);
    check("reset tok_out",   {3'd0, tok_out},   4'd0);
    check("reset ev_ready",  {3'd0, ev_ready},  4'd1);
    rst_n = 1'b1;
    @(negedge clk);

    cur_req = "R2 R3 R6 R7";
    send({4{32'hA5C3_0F1E}}, 2'd0);
    check("R2 busy ev_ready", {3'd0, ev_ready}, 4'd0);
    send(rnd128(), 2'd0);       // offered while busy: back-pressure
    send(128'h1, 2'd0);
    wait_idle();

    cur_req = "R4 R6 R7";
    send(rnd128(), 2'd1);
    send({64'hFFFF_0000_1234_5678, 64'h8000_0000_0000_0001}, 2'd1);
    wait_idle();

    cur_req = "R5 R6 R7";
    send(rnd128(), 2'd2);
    send({1'b1, 126'd0, 1'b1}, 2'd2);
    wait_idle();

    cur_req = "R8";
    send(rnd128(), 2'd0);
    repeat (5) @(negedge clk);
    mode = 2'd2;
    repeat (5) @(negedge clk);
    mode = 2'd1;
    wait_idle();
    send(rnd128(), 2'd2);
    repeat (3) @(negedge clk);
    mode = 2'd0;
    wait_idle();

    cur_req = "R9 R10";
    tok_before = tok_seen;
    send(rnd128(), 2'd3);
    repeat (15) @(negedge clk);
    check("R9 held without token", {3'd0, ser_valid}, 4'd0);
    pulse_tok();
    wait_idle();
    check("R10 token pulses", 4'(tok_seen - tok_before), 4'd1);
    tok_before = tok_seen;
    tok_in = 1'b1;
    send(rnd128(), 2'd3);
    tok_in = 1'b0;
    wait_idle();
    check("R9 R10 token at accept", 4'(tok_seen - tok_before), 4'd1);

    cur_req = "R11";
    tok_before = tok_seen;
    mode = 2'd3;
    pulse_tok();
    repeat (3) @(negedge clk);
    check("R11 forwarded token", 4'(tok_seen - tok_before), 4'd1);

    cur_req = "R12";
    tok_before = tok_seen;
    mode = 2'd0;
    pulse_tok();
    send(rnd128(), 2'd1);
    repeat (4) @(negedge clk);
    pulse_tok();
    wait_idle();
    mode = 2'd2;
    pulse_tok();
    repeat (3) @(negedge clk);
    check("R12 no token out", 4'(tok_seen - tok_before), 4'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired in %s", cur_req);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule